// File: doc/BRIEF.md
# DMA Error Status Capture Register

This block keeps the error records for the DMA side of a host bridge. Error detectors elsewhere in the bridge send each error as a one-cycle event. The event carries its class, its kind, the byte mask, the doubleword offset, a block-transfer flag, an ECC syndrome and the faulting address. The block keeps one record for uncorrectable errors and one for correctable errors. In each record, the first error is marked as primary and its details are frozen. Errors that follow are marked only as secondary.

A single fault-address register serves both records. It holds the address of the most recent error that became primary in either record, and it can be read at two offsets. Software reads the records through a small register port and clears flags by writing ones to them. A registered, level-sensitive interrupt stays raised while the interrupt enable is set and any flag in either record is set.

Register offsets on `reg_addr` are:
- 0x00: uncorrectable status.
- 0x08: correctable status.
- 0x10: fault address.
- 0x18: fault address alias.
- 0x20: control. Bit 0 is the interrupt enable.

Other offsets read as zero. Event encodings are:
- `evt_uncorr`: 1 for uncorrectable, 0 for correctable.
- `evt_kind`: 0 = DMA read, 1 = DMA write, 2 = translation error, 3 = reserved.

Top module: `dma_err_capture`

## Requirements
- R1: After reset, both status words, the fault address and the control register read zero, and `err_irq` is low.
- R2: An event enters a record as primary when that record has no primary flag set, after any clear written in the same cycle. It sets the primary flag for its kind and loads the record's detail fields and the fault address, with the fields placed as follows.
  - Primary read flag: bit 62.
  - Primary write flag: bit 61.
  - Primary translation flag (uncorrectable record only): bit 56.
  - Byte mask: bits 47:32.
  - Doubleword offset: bits 31:29.
  - Block flag: bit 23.
- R3: An event that arrives while its record already holds a primary flag sets only the secondary flag for its kind. The secondary flags are read at bit 59, write at bit 58 and translation at bit 57. The details and the fault address are left unchanged. Each record decides this independently of the other record.
- R4: Translation-error events set bit 56 or bit 57 of the uncorrectable record only. A translation event to the correctable record, and any event of the reserved kind, changes no flag, field or address.
- R5: The correctable record keeps the 8-bit syndrome of its primary error in bits 55:48. In the uncorrectable status these bits always read zero.
- R6: A write to a status offset clears exactly the flags whose bits are one in the written value. All other flags stay as they were.
- R7: When an event and a clearing write to the same record fall in the same cycle, the event's own flag ends up set. A primary flag cleared in that cycle no longer blocks the event from becoming primary.
- R8: The fault address reads the same at 0x10 and 0x18. It is loaded by a primary error in either record.
- R9: `err_irq` goes high one cycle after the enable and at least one flag are both set. It goes low one cycle after the last flag is cleared or the enable is cleared.
- R10: Control bit 0 can be written and read back. Writes to the address offsets, and to non-flag bits of the status words, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | One-cycle error event strobe |
| evt_uncorr | input | 1 | Event class: 1 uncorrectable, 0 correctable |
| evt_kind | input | 2 | 0 read, 1 write, 2 translation, 3 reserved |
| evt_bmask | input | 16 | Byte mask of the failing transfer |
| evt_dw_off | input | 3 | Doubleword offset (address bits 5:3) |
| evt_block | input | 1 | Failing transfer was a block operation |
| evt_syndrome | input | 8 | ECC syndrome (used by the correctable record) |
| evt_addr | input | 64 | Faulting address |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| err_irq | output | 1 | Level error interrupt |

## Verification
The assertions assume that at most one event arrives in each cycle, so the two records never compete for the shared address register. They also assume that the event strobe lasts exactly one cycle. The directed stimulus raises `evt_valid` for one cycle at a time and never presents two events together. Every scenario that combines an event with a clearing write uses the register port's single write slot in that same cycle.

// File: rtl/dmaerr_pkg.sv
// Shared encodings for the DMA error capture block.
// Assumes 64-bit status words with fixed field positions.
package dmaerr_pkg;

    typedef enum logic [1:0] {
        KIND_RD   = 2'd0,
        KIND_WR   = 2'd1,
        KIND_XL   = 2'd2,
        KIND_RSVD = 2'd3
    } err_kind_e;

    localparam int BIT_P_RD = 62;
    localparam int BIT_P_WR = 61;
    localparam int BIT_S_RD = 59;
    localparam int BIT_S_WR = 58;
    localparam int BIT_S_XL = 57;
    localparam int BIT_P_XL = 56;
    localparam int SYN_LO   = 48;
    localparam int BM_LO    = 32;
    localparam int OFF_LO   = 29;
    localparam int BLK_BIT  = 23;

    localparam logic [5:0] OFF_UE_STAT = 6'h00;
    localparam logic [5:0] OFF_CE_STAT = 6'h08;
    localparam logic [5:0] OFF_ADDR    = 6'h10;
    localparam logic [5:0] OFF_ADDR_AL = 6'h18;
    localparam logic [5:0] OFF_CTRL    = 6'h20;

    // Map an error kind to a {xlate, write, read} one-hot vector
    function automatic logic [2:0] kind_onehot(err_kind_e k);
        case (k)
            KIND_RD: return 3'b001;
            KIND_WR: return 3'b010;
            KIND_XL: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/err_record.sv
// One error record: primary/secondary flags plus frozen detail fields.
// The first error, seen against the flags as they stand after any clear in
// the same cycle, becomes primary and loads the details. Later errors only
// set secondary flags. Assumes evt_hit is a one-cycle strobe.
module err_record
    import dmaerr_pkg::*;
#(
    parameter int BM_W    = 16,
    parameter int OFF_W   = 3,
    parameter int SYN_W   = 8,
    parameter int REG_W   = 64,
    parameter bit HAS_XL  = 1'b1,
    parameter bit HAS_SYN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_hit,
    input  err_kind_e        evt_kind,
    input  logic [BM_W-1:0]  evt_bmask,
    input  logic [OFF_W-1:0] evt_off,
    input  logic             evt_blk,
    input  logic [SYN_W-1:0] evt_syn,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] status,
    output logic             took_primary,
    output logic             flag_any
);

    localparam logic [2:0] KIND_MASK = HAS_XL ? 3'b111 : 3'b011;
    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << BIT_P_RD) | (REG_W'(1) << BIT_P_WR) |
        (REG_W'(1) << BIT_S_RD) | (REG_W'(1) << BIT_S_WR) |
        (HAS_XL ? ((REG_W'(1) << BIT_S_XL) | (REG_W'(1) << BIT_P_XL)) : '0);

    logic [2:0]       prim_q, sec_q, prim_kept, sec_kept, clr_prim, clr_sec, evt_vec;
    logic             take_prim;
    logic [BM_W-1:0]  bm_q;
    logic [OFF_W-1:0] off_q;
    logic             blk_q;
    logic [SYN_W-1:0] syn_q;
    logic [SYN_W-1:0] syn_field;
    logic             unused_clr_bits;

    assign unused_clr_bits = ^clr_data;

    // Decode which flags the write-one-to-clear access targets
    assign clr_prim = clr_we ? ({clr_data[BIT_P_XL], clr_data[BIT_P_WR], clr_data[BIT_P_RD]} & KIND_MASK) : 3'b000;
    assign clr_sec  = clr_we ? ({clr_data[BIT_S_XL], clr_data[BIT_S_WR], clr_data[BIT_S_RD]} & KIND_MASK) : 3'b000;

    // Event vector, restricted to the kinds this record tracks
    assign evt_vec   = evt_hit ? (kind_onehot(evt_kind) & KIND_MASK) : 3'b000;
    assign prim_kept = prim_q & ~clr_prim;
    assign sec_kept  = sec_q & ~clr_sec;
    assign take_prim = (|evt_vec) && !(|prim_kept);

    // Flag update: clear first, then the event sets its own flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q <= 3'b000;
            sec_q  <= 3'b000;
        end else begin
            prim_q <= prim_kept | (take_prim ? evt_vec : 3'b000);
            sec_q  <= sec_kept | (take_prim ? 3'b000 : evt_vec);
        end
    end

    // Detail capture, only on a new primary error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bm_q  <= '0;
            off_q <= '0;
            blk_q <= 1'b0;
            syn_q <= '0;
        end else if (take_prim) begin
            bm_q  <= evt_bmask;
            off_q <= evt_off;
            blk_q <= evt_blk;
            syn_q <= evt_syn;
        end
    end

    assign syn_field = HAS_SYN ? syn_q : '0;

    // Assemble the software-visible status word
    always_comb begin
        status = '0;
        status[BIT_P_RD] = prim_q[0];
        status[BIT_P_WR] = prim_q[1];
        status[BIT_P_XL] = prim_q[2];
        status[BIT_S_RD] = sec_q[0];
        status[BIT_S_WR] = sec_q[1];
        status[BIT_S_XL] = sec_q[2];
        status[SYN_LO +: SYN_W] = syn_field;
        status[BM_LO +: BM_W]   = bm_q;
        status[OFF_LO +: OFF_W] = off_q;
        status[BLK_BIT]         = blk_q;
    end

    assign took_primary = take_prim;
    assign flag_any     = |{prim_q, sec_q};

    // A pure clear leaves none of the written flags set
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !evt_hit) |=> ((status & $past(clr_data & FLAG_MASK)) == '0));

    // Details stay frozen while a primary error is held and not cleared
    assert_details_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && (|prim_q) && !clr_we) |=> $stable(status[SYN_LO+SYN_W-1:0]));

    // A read event always leaves a read flag set (event wins, R7)
    assert_read_event_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && evt_kind == KIND_RD) |=> (status[BIT_P_RD] || status[BIT_S_RD]));

endmodule

// File: rtl/fault_addr_reg.sv
// Shared faulting-address register, loaded when either record takes a
// primary error. Assumes at most one load source is active per cycle.
module fault_addr_reg #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    // Hold the address of the latest primary error
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_in;
    end

    assert_addr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_q));

endmodule

// File: rtl/irq_gen.sv
// Registered level interrupt: enable AND any pending flag, one cycle late.
module irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pending,
    output logic irq
);

    // Register the gated pending level
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= enable & pending;
    end

    assert_irq_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pending) |=> irq);

    assert_irq_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && pending) |=> !irq);

endmodule

// File: rtl/dma_err_capture.sv
// DMA error status capture: an uncorrectable and a correctable record, a
// shared fault-address register, an interrupt enable and a level interrupt.
// Assumes one error event per cycle; register reads are combinational.
module dma_err_capture
    import dmaerr_pkg::*;
#(
    parameter int BM_W   = 16,
    parameter int OFF_W  = 3,
    parameter int SYN_W  = 8,
    parameter int DATA_W = 64,
    parameter int RA_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_uncorr,
    input  logic [1:0]        evt_kind,
    input  logic [BM_W-1:0]   evt_bmask,
    input  logic [OFF_W-1:0]  evt_dw_off,
    input  logic              evt_block,
    input  logic [SYN_W-1:0]  evt_syndrome,
    input  logic [DATA_W-1:0] evt_addr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              err_irq
);

    logic              ue_hit, ce_hit, ue_clr, ce_clr, ctrl_we;
    logic [DATA_W-1:0] ue_status, ce_status, fault_addr;
    logic              ue_take, ce_take, ue_any, ce_any;
    logic              irq_en_q;
    err_kind_e         kind;

    assign kind    = err_kind_e'(evt_kind);
    assign ue_hit  = evt_valid && evt_uncorr;
    assign ce_hit  = evt_valid && !evt_uncorr;
    assign ue_clr  = reg_wr && (reg_addr == RA_W'(OFF_UE_STAT));
    assign ce_clr  = reg_wr && (reg_addr == RA_W'(OFF_CE_STAT));
    assign ctrl_we = reg_wr && (reg_addr == RA_W'(OFF_CTRL));

    err_record #(
        .BM_W(BM_W), .OFF_W(OFF_W), .SYN_W(SYN_W), .REG_W(DATA_W),
        .HAS_XL(1'b1), .HAS_SYN(1'b0)
    ) u_ue_rec (
        .clk(clk), .rst_n(rst_n),
        .evt_hit(ue_hit), .evt_kind(kind),
        .evt_bmask(evt_bmask), .evt_off(evt_dw_off),
        .evt_blk(evt_block), .evt_syn(evt_syndrome),
        .clr_we(ue_clr), .clr_data(reg_wdata),
        .status(ue_status), .took_primary(ue_take), .flag_any(ue_any)
    );

    err_record #(
        .BM_W(BM_W), .OFF_W(OFF_W), .SYN_W(SYN_W), .REG_W(DATA_W),
        .HAS_XL(1'b0), .HAS_SYN(1'b1)
    ) u_ce_rec (
        .clk(clk), .rst_n(rst_n),
        .evt_hit(ce_hit), .evt_kind(kind),
        .evt_bmask(evt_bmask), .evt_off(evt_dw_off),
        .evt_blk(evt_block), .evt_syn(evt_syndrome),
        .clr_we(ce_clr), .clr_data(reg_wdata),
        .status(ce_status), .took_primary(ce_take), .flag_any(ce_any)
    );

    fault_addr_reg #(.ADDR_W(DATA_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(ue_take || ce_take), .addr_in(evt_addr),
        .addr_q(fault_addr)
    );

    // Interrupt enable control bit
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_en_q <= 1'b0;
        else if (ctrl_we) irq_en_q <= reg_wdata[0];
    end

    irq_gen u_irq (
        .clk(clk), .rst_n(rst_n),
        .enable(irq_en_q), .pending(ue_any || ce_any),
        .irq(err_irq)
    );

    // Register read multiplexer
    always_comb begin
        case (reg_addr)
            RA_W'(OFF_UE_STAT): reg_rdata = ue_status;
            RA_W'(OFF_CE_STAT): reg_rdata = ce_status;
            RA_W'(OFF_ADDR):    reg_rdata = fault_addr;
            RA_W'(OFF_ADDR_AL): reg_rdata = fault_addr;
            RA_W'(OFF_CTRL):    reg_rdata = {{(DATA_W-1){1'b0}}, irq_en_q};
            default:            reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/dma_err_capture_tb.sv
// Directed bench for the DMA error capture block: one task per scenario.
module dma_err_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_uncorr = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic [15:0] evt_bmask = '0;
    logic [2:0]  evt_dw_off = '0;
    logic        evt_block = 1'b0;
    logic [7:0]  evt_syndrome = '0;
    logic [63:0] evt_addr = '0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        err_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [63:0] P_RD = 64'd1 << 62;
    localparam logic [63:0] P_WR = 64'd1 << 61;
    localparam logic [63:0] S_RD = 64'd1 << 59;
    localparam logic [63:0] S_WR = 64'd1 << 58;
    localparam logic [63:0] S_XL = 64'd1 << 57;
    localparam logic [63:0] P_XL = 64'd1 << 56;
    localparam logic [63:0] ALL1 = '1;
    localparam logic [63:0] A1 = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] A2 = 64'h0000_0000_0000_1000;
    localparam logic [63:0] A3 = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] A4 = 64'h0000_0000_0BAD_F00D;
    localparam logic [63:0] A5 = 64'h0000_0001_0000_0040;
    localparam logic [63:0] A6 = 64'h0000_0002_0000_0080;
    localparam logic [63:0] A7 = 64'h0000_0003_0000_00C0;
    localparam logic [63:0] A8 = 64'h0000_0004_0000_0100;
    localparam logic [63:0] A9 = 64'h0000_0005_0000_0140;

    dma_err_capture u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_uncorr(evt_uncorr), .evt_kind(evt_kind),
        .evt_bmask(evt_bmask), .evt_dw_off(evt_dw_off), .evt_block(evt_block),
        .evt_syndrome(evt_syndrome), .evt_addr(evt_addr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_irq(err_irq)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] det(logic [15:0] bm, logic [2:0] off, logic blk, logic [7:0] syn);
        return (64'(syn) << 48) | (64'(bm) << 32) | (64'(off) << 29) | (64'(blk) << 23);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_check(string tag, logic [5:0] a, logic [63:0] exp);
        logic [63:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic drive_evt(logic cls, logic [1:0] k, logic [15:0] bm, logic [2:0] off,
                             logic blk, logic [7:0] syn, logic [63:0] a);
        evt_valid = 1'b1; evt_uncorr = cls; evt_kind = k; evt_bmask = bm;
        evt_dw_off = off; evt_block = blk; evt_syndrome = syn; evt_addr = a;
    endtask

    task automatic ev(logic cls, logic [1:0] k, logic [15:0] bm, logic [2:0] off,
                      logic blk, logic [7:0] syn, logic [63:0] a);
        @(negedge clk);
        drive_evt(cls, k, bm, off, blk, syn, a);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr(logic [5:0] a, logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ev_and_wr(logic cls, logic [1:0] k, logic [15:0] bm, logic [2:0] off,
                             logic blk, logic [63:0] a, logic [5:0] wa, logic [63:0] wd);
        @(negedge clk);
        drive_evt(cls, k, bm, off, blk, 8'h00, a);
        reg_addr = wa; reg_wdata = wd; reg_wr = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 irq after reset", 64'(err_irq), 64'd0);
        rd_check("R1 ue status", 6'h00, 64'd0);
        rd_check("R1 ce status", 6'h08, 64'd0);
        rd_check("R1 address", 6'h10, 64'd0);
        rd_check("R1 address alias", 6'h18, 64'd0);
        rd_check("R1 control", 6'h20, 64'd0);
    endtask

    task automatic t_primary;
        wr(6'h20, 64'd1);
        ev(1'b1, 2'd0, 16'hA5A5, 3'd5, 1'b1, 8'h3C, A1);
        check("R9 irq not yet high", 64'(err_irq), 64'd0);
        @(negedge clk);
        check("R9 irq high one cycle later", 64'(err_irq), 64'd1);
        rd_check("R2 ue primary read, R5 no syndrome", 6'h00, P_RD | det(16'hA5A5, 3'd5, 1'b1, 8'h00));
        rd_check("R8 address", 6'h10, A1);
        rd_check("R8 address alias", 6'h18, A1);
        rd_check("R2 ce untouched", 6'h08, 64'd0);
    endtask

    task automatic t_secondary;
        ev(1'b1, 2'd1, 16'h0F0F, 3'd2, 1'b0, 8'h00, A2);
        rd_check("R3 ue secondary write", 6'h00, P_RD | S_WR | det(16'hA5A5, 3'd5, 1'b1, 8'h00));
        rd_check("R3 address kept", 6'h10, A1);
        ev(1'b0, 2'd0, 16'h1234, 3'd7, 1'b0, 8'hC3, A3);
        rd_check("R3 R5 ce own primary with syndrome", 6'h08, P_RD | det(16'h1234, 3'd7, 1'b0, 8'hC3));
        rd_check("R8 address from ce primary", 6'h18, A3);
        ev(1'b0, 2'd1, 16'hFFFF, 3'd1, 1'b1, 8'h11, A4);
        rd_check("R3 ce secondary write", 6'h08, P_RD | S_WR | det(16'h1234, 3'd7, 1'b0, 8'hC3));
        rd_check("R3 address after ce secondary", 6'h10, A3);
    endtask

    task automatic t_w1c;
        wr(6'h00, S_WR | 64'h0000_FFFF_E080_0000);
        rd_check("R6 R10 clear one flag only", 6'h00, P_RD | det(16'hA5A5, 3'd5, 1'b1, 8'h00));
        wr(6'h10, ALL1);
        rd_check("R10 address write ignored", 6'h10, A3);
        wr(6'h18, ALL1);
        rd_check("R10 alias write ignored", 6'h18, A3);
        wr(6'h00, ALL1);
        check("R9 irq held while ce flags set", 64'(err_irq), 64'd1);
        wr(6'h08, ALL1);
        check("R9 irq still high right after last clear", 64'(err_irq), 64'd1);
        @(negedge clk);
        check("R9 irq low one cycle later", 64'(err_irq), 64'd0);
        rd_check("R6 ue details kept after clear", 6'h00, det(16'hA5A5, 3'd5, 1'b1, 8'h00));
        rd_check("R6 ce details kept after clear", 6'h08, det(16'h1234, 3'd7, 1'b0, 8'hC3));
    endtask

    task automatic t_xlate;
        ev(1'b1, 2'd2, 16'h00FF, 3'd1, 1'b1, 8'h00, A5);
        rd_check("R4 ue primary translation", 6'h00, P_XL | det(16'h00FF, 3'd1, 1'b1, 8'h00));
        rd_check("R4 address", 6'h10, A5);
        ev(1'b1, 2'd2, 16'h7777, 3'd3, 1'b0, 8'h00, A6);
        rd_check("R4 ue secondary translation", 6'h00, P_XL | S_XL | det(16'h00FF, 3'd1, 1'b1, 8'h00));
        ev(1'b0, 2'd2, 16'h5555, 3'd4, 1'b1, 8'h99, A7);
        rd_check("R4 ce ignores translation", 6'h08, det(16'h1234, 3'd7, 1'b0, 8'hC3));
        rd_check("R4 address unchanged by ignored event", 6'h10, A5);
        ev(1'b0, 2'd3, 16'h5555, 3'd4, 1'b1, 8'h99, A7);
        rd_check("R4 ce ignores reserved kind", 6'h08, det(16'h1234, 3'd7, 1'b0, 8'hC3));
        ev(1'b1, 2'd3, 16'h5555, 3'd4, 1'b1, 8'h99, A7);
        rd_check("R4 ue ignores reserved kind", 6'h00, P_XL | S_XL | det(16'h00FF, 3'd1, 1'b1, 8'h00));
    endtask

    task automatic t_same_cycle;
        ev_and_wr(1'b1, 2'd0, 16'hBEEF, 3'd6, 1'b0, A8, 6'h00, P_XL);
        rd_check("R7 cleared primary lets event become primary", 6'h00, P_RD | S_XL | det(16'hBEEF, 3'd6, 1'b0, 8'h00));
        rd_check("R7 address from new primary", 6'h10, A8);
        ev_and_wr(1'b1, 2'd0, 16'h1111, 3'd0, 1'b1, A9, 6'h00, S_RD);
        rd_check("R7 event wins over clear of its flag", 6'h00, P_RD | S_RD | S_XL | det(16'hBEEF, 3'd6, 1'b0, 8'h00));
        rd_check("R7 address kept for secondary", 6'h18, A8);
    endtask

    task automatic t_irq_gate;
        wr(6'h20, 64'd0);
        check("R9 irq still high right after disable", 64'(err_irq), 64'd1);
        @(negedge clk);
        check("R9 irq low after disable", 64'(err_irq), 64'd0);
        rd_check("R10 control reads zero", 6'h20, 64'd0);
        wr(6'h20, ALL1);
        check("R9 irq low right after enable", 64'(err_irq), 64'd0);
        @(negedge clk);
        check("R9 irq high after enable", 64'(err_irq), 64'd1);
        rd_check("R10 control reads one", 6'h20, 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_primary;
        t_secondary;
        t_w1c;
        t_xlate;
        t_same_cycle;
        t_irq_gate;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule